// File: doc/BRIEF.md
# Multiplex-Aware Segment Memory Loader

This block sits between a serial-bus receiver and a small segment memory of 40 words, each 4 bits wide. Each word drives one segment line. Bit r of a word is the segment's value during backplane phase r. The receiver hands over whole display bytes. The loader spreads each byte over one or more consecutive words, and the drive mode sets how many rows of each word take bits. A static display uses only row 0. A two-phase display fills rows 0 and 1. A three-phase display fills rows 0 to 2. A four-phase display fills all four rows.

A data pointer selects the word being written. The host sets the pointer with a load strobe. After that, each stored word moves the pointer on by one, so a stream of bytes fills the memory without further addressing. The loader writes one word per clock. While it is still working through a byte, it raises a hold flag, and the bus front end then stretches the bus clock instead of offering a new byte. When the pointer steps past the last word, it returns to word 0 and the loader gives a one-cycle pulse. A cascaded neighbour can use that pulse to take over the rest of the stream.

Top module: `seg_ram_loader`

## Requirements
- R1: Static mode (mode code 2'b01): a byte is written into row 0 of 8 consecutive words. Byte bit 7 goes to the first word and bit 0 to the last. Only row 0 is enabled, and each write takes one cycle.
- R2: Two-phase mode (code 2'b10): a byte fills rows 0 and 1 of 4 consecutive words. The bit pairs are taken from the top of the byte downward, and the more significant bit of each pair goes to row 0.
- R3: Three-phase mode (code 2'b11): bits 7,6,5 go to rows 0,1,2 of the first word and bits 4,3,2 to rows 0,1,2 of the second word. Bits 1,0 go to rows 0,1 of a third word, and that third write leaves rows 2 and 3 of that word untouched.
- R4: Four-phase mode (code 2'b00): bits 7..4 go to rows 0..3 of the first word, with bit 7 in row 0. Bits 3..0 go to rows 0..3 of the next word.
- R5: The pointer advances by one after every word write, so the next byte starts at the word after the one the previous byte ended on.
- R6: An accepted pointer load sets the pointer to ptr_in, or to 0 if ptr_in is 40 or more. When no write is in progress, wr_addr shows the current pointer.
- R7: After a write to word 39 the pointer moves to 0, and wrap_pulse is high for exactly the one cycle that follows that write.
- R8: While cs is low, byte_vld and ptr_ld are ignored. No write starts and the pointer does not change.
- R9: busy goes high in the cycle after a byte is accepted. It stays high for exactly as many cycles as the byte has word writes. A byte offered while busy is high is not taken until busy has dropped, and it is then stored in full.
- R10: At most one word is written per cycle. wr_data is 0 in every row that is not enabled in wr_mask, and back-to-back writes go to consecutive addresses.
- R11: The drive mode is sampled when a byte is accepted. Changing it while that byte is being stored has no effect on that byte.
- R12: After reset: busy, wr_en, wr_mask and wrap_pulse are 0, and the pointer (wr_addr) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device-selected qualifier from the bus front end |
| mode | input | 2 | Drive mode: 00 four-phase, 01 static, 10 two-phase, 11 three-phase |
| ptr_ld | input | 1 | Pointer-load strobe |
| ptr_in | input | 6 | Pointer value to load |
| byte_vld | input | 1 | Display byte offered |
| byte_in | input | 8 | Display byte |
| wr_en | output | 1 | Memory word write enable |
| wr_addr | output | 6 | Write address (current pointer) |
| wr_mask | output | 4 | Row enables for the write |
| wr_data | output | 4 | Row data for the write |
| busy | output | 1 | Hold request: stretch the bus clock |
| wrap_pulse | output | 1 | One-cycle pulse after the pointer wraps past word 39 |

## Verification
The bench uses the default size of 40 words, so the pointer width works out to 6 bits. Starting a byte near word 39 makes the wrap and the cascade pulse happen within a few writes. The 6-bit pointer input can also carry the out-of-range values 40 to 63, which lets the bench exercise the clamp to word 0. The bench keeps its own model of the memory, built by placing bits row by row. After each scenario it compares that model against the memory rebuilt from the write port.

// File: rtl/segld_pkg.sv
package segld_pkg;

  typedef enum logic [1:0] {
    DM_MUX4 = 2'b00,
    DM_STAT = 2'b01,
    DM_MUX2 = 2'b10,
    DM_MUX3 = 2'b11
  } drive_mode_e;

  // Number of word writes one byte needs in a given mode.
  function automatic logic [3:0] words_per_byte(drive_mode_e m);
    case (m)
      DM_STAT: return 4'd8;
      DM_MUX2: return 4'd4;
      DM_MUX3: return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

  // Row enables for one word write; 'last' marks the final word of a byte.
  function automatic logic [3:0] rows_enabled(drive_mode_e m, logic last);
    case (m)
      DM_STAT: return 4'b0001;
      DM_MUX2: return 4'b0011;
      DM_MUX3: return last ? 4'b0011 : 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // Bits consumed from the byte by one write with the given row enables.
  function automatic logic [2:0] bits_used(logic [3:0] mk);
    return {2'b00, mk[0]} + {2'b00, mk[1]} + {2'b00, mk[2]} + {2'b00, mk[3]};
  endfunction

endpackage

// File: rtl/segld_pointer.sv
module segld_pointer #(
  parameter int WORDS = 40,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          wrapped
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic at_last;
  assign at_last = (ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      wrapped <= 1'b0;
    end else begin
      wrapped <= step && at_last;
      if (load)
        ptr <= (int'(load_val) < WORDS) ? load_val : '0;
      else if (step)
        ptr <= at_last ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/segld_packer.sv
module segld_packer
  import segld_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      byte_in,
  input  drive_mode_e     mode_in,
  output logic            active,
  output logic [ROWS-1:0] mask,
  output logic [ROWS-1:0] data
);
  logic [7:0]  shreg;
  logic [3:0]  left;
  drive_mode_e mode_q;
  logic        last;

  assign active = (left != 4'd0);
  assign last   = (left == 4'd1);
  assign mask   = active ? ROWS'(rows_enabled(mode_q, last)) : '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign data[r] = mask[r] & shreg[7-r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      left   <= '0;
      mode_q <= DM_STAT;
    end else if (start) begin
      shreg  <= byte_in;
      left   <= words_per_byte(mode_in);
      mode_q <= mode_in;
    end else if (active) begin
      shreg  <= shreg << bits_used(4'(mask));
      left   <= left - 4'd1;
    end
  end
endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
  import segld_pkg::*;
#(
  parameter int WORDS = 40,
  localparam int AW   = $clog2(WORDS),
  localparam int ROWS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic [1:0]      mode,
  input  logic            ptr_ld,
  input  logic [AW-1:0]   ptr_in,
  input  logic            byte_vld,
  input  logic [7:0]      byte_in,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [ROWS-1:0] wr_mask,
  output logic [ROWS-1:0] wr_data,
  output logic            busy,
  output logic            wrap_pulse
);
  logic accept_byte;
  logic accept_load;
  logic step;

  assign accept_byte = byte_vld && cs && !busy;
  assign accept_load = ptr_ld && cs && !busy;

  segld_packer #(.ROWS(ROWS)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept_byte),
    .byte_in (byte_in),
    .mode_in (drive_mode_e'(mode)),
    .active  (busy),
    .mask    (wr_mask),
    .data    (wr_data)
  );

  assign step  = busy;
  assign wr_en = step;

  segld_pointer #(.WORDS(WORDS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_load),
    .load_val (ptr_in),
    .step     (step),
    .ptr      (wr_addr),
    .wrapped  (wrap_pulse)
  );
endmodule

// File: rtl/segld_checker.sv
module segld_checker #(
  parameter int WORDS = 40,
  localparam int AW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          accept_byte,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_mask,
  input logic [3:0]    wr_data,
  input logic          busy,
  input logic          wrap_pulse
);
  assert_mask_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mask != 4'd0));

  assert_data_in_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~wr_mask) == 4'd0));

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_addr) < WORDS);

  assert_seq_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |->
      (wr_addr == ((int'($past(wr_addr)) == WORDS-1) ? '0 : $past(wr_addr) + 1'b1)));

  assert_wrap_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ($past(wr_en) && int'($past(wr_addr)) == WORDS-1 && wr_addr == '0));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_byte |=> busy);

  assert_cs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !busy) |=> !busy);
endmodule

bind seg_ram_loader segld_checker #(.WORDS(WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs          (cs),
  .accept_byte (accept_byte),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_mask     (wr_mask),
  .wr_data     (wr_data),
  .busy        (busy),
  .wrap_pulse  (wrap_pulse)
);

// File: tb/tb_seg_ram_loader.sv
`timescale 1ns/1ps
module tb_seg_ram_loader;
  localparam int WORDS = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       ptr_ld = 1'b0;
  logic [5:0] ptr_in = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic       wr_en, busy, wrap_pulse;
  logic [5:0] wr_addr;
  logic [3:0] wr_mask, wr_data;

  int n_tests = 0, n_fail = 0;
  int wr_count = 0, wrap_count = 0;
  logic [3:0] obs_mem [WORDS];
  logic [3:0] exp_mem [WORDS];
  int exp_ptr = 0;

  always #4 clk = ~clk;

  seg_ram_loader dut (.*);

  // Rebuild memory contents from the write port, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      wr_count++;
      for (int r = 0; r < 4; r++) if (wr_mask[r]) obs_mem[wr_addr][r] = wr_data[r];
    end
    if (wrap_pulse) wrap_count++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0, first = -1;
    for (int w = 0; w < WORDS; w++)
      if (obs_mem[w] !== exp_mem[w]) begin bad++; if (first < 0) first = w; end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(obs_mem[first]), int'(exp_mem[first]));
  endtask

  // Reference placement: walk the byte bit by bit, filling rows in order
  task automatic model_byte(input logic [7:0] b, input logic [1:0] m);
    int rows = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : (m == 2'b11) ? 3 : 4;
    int r = 0;
    for (int i = 7; i >= 0; i--) begin
      exp_mem[exp_ptr][r] = b[i];
      r++;
      if (r == rows) begin r = 0; exp_ptr = (exp_ptr == WORDS-1) ? 0 : exp_ptr + 1; end
    end
    if (r != 0) exp_ptr = (exp_ptr == WORDS-1) ? 0 : exp_ptr + 1;
  endtask

  function automatic int groups_of(input logic [1:0] m);
    int rows = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : (m == 2'b11) ? 3 : 4;
    return (8 + rows - 1) / rows;
  endfunction

  task automatic load_ptr(input logic [5:0] p);
    @(negedge clk);
    ptr_ld = 1'b1; ptr_in = p;
    @(negedge clk);
    ptr_ld = 1'b0;
    exp_ptr = (p < WORDS) ? int'(p) : 0;
  endtask

  // Offer a byte; optionally change mode right after acceptance; return busy cycles
  task automatic send_byte(input logic [7:0] b, input logic chg, output int busy_cyc);
    logic [1:0] m = mode;
    @(negedge clk);
    while (busy) @(negedge clk);
    byte_vld = 1'b1; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0;
    if (chg) mode = ~mode;
    busy_cyc = 0;
    while (busy) begin busy_cyc++; @(negedge clk); end
    if (chg) mode = m;
    model_byte(b, m);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!busy && !wr_en && wr_mask == 0 && !wrap_pulse, "R12 idle outputs", int'(busy), 0);
    check(wr_addr == 0, "R12 pointer", int'(wr_addr), 0);
  endtask

  task automatic t_static;
    int bc, w0;
    mode = 2'b01; load_ptr(6'd0);
    w0 = wr_count;
    send_byte(8'hA5, 1'b0, bc);
    check(bc == groups_of(2'b01), "R1 busy cycles", bc, 8);
    check(wr_count - w0 == 8, "R1 write count", wr_count - w0, 8);
    check(obs_mem[0][0] == 1'b1 && obs_mem[1][0] == 1'b0, "R1 MSB first", int'(obs_mem[1]), 0);
    compare_mem("R1 static packing");
  endtask

  task automatic t_mux2;
    int bc;
    mode = 2'b10; load_ptr(6'd10);
    send_byte(8'hC6, 1'b0, bc);
    check(bc == 4, "R2 busy cycles", bc, 4);
    compare_mem("R2 two-phase packing");
  endtask

  task automatic t_mux3;
    int bc;
    mode = 2'b11; load_ptr(6'd20);
    send_byte(8'hB7, 1'b0, bc);
    check(bc == 3, "R3 busy cycles", bc, 3);
    check(wr_addr == 23, "R5 pointer after byte", int'(wr_addr), 23);
    send_byte(8'h5A, 1'b0, bc);
    compare_mem("R3 three-phase packing, R5 continuation");
  endtask

  task automatic t_mux4;
    int bc;
    mode = 2'b00; load_ptr(6'd30);
    send_byte(8'h9C, 1'b0, bc);
    send_byte(8'h3E, 1'b0, bc);
    check(bc == 2, "R4 busy cycles", bc, 2);
    check(wr_addr == 34, "R5 pointer", int'(wr_addr), 34);
    compare_mem("R4 four-phase packing");
  endtask

  task automatic t_wrap;
    int bc, wc0;
    mode = 2'b00; load_ptr(6'd39);
    wc0 = wrap_count;
    send_byte(8'hF0, 1'b0, bc);
    check(wrap_count - wc0 == 1, "R7 wrap pulse count", wrap_count - wc0, 1);
    check(wr_addr == 1, "R7 pointer after wrap", int'(wr_addr), 1);
    compare_mem("R7 wrapped data");
    @(negedge clk);
    check(!wrap_pulse, "R7 pulse length", int'(wrap_pulse), 0);
  endtask

  task automatic t_cs_low;
    int w0 = wr_count;
    logic [5:0] a0 = wr_addr;
    @(negedge clk);
    cs = 1'b0; byte_vld = 1'b1; byte_in = 8'hFF; ptr_ld = 1'b1; ptr_in = 6'd5;
    @(negedge clk);
    byte_vld = 1'b0; ptr_ld = 1'b0;
    check(!busy, "R8 no start with cs low", int'(busy), 0);
    @(negedge clk);
    check(wr_count == w0, "R8 no writes", wr_count - w0, 0);
    check(wr_addr == a0, "R8 pointer unchanged", int'(wr_addr), int'(a0));
    cs = 1'b1;
    compare_mem("R8 memory unchanged");
  endtask

  task automatic t_load_range;
    load_ptr(6'd45);
    check(wr_addr == 0, "R6 out-of-range load", int'(wr_addr), 0);
    load_ptr(6'd17);
    check(wr_addr == 17, "R6 load value", int'(wr_addr), 17);
  endtask

  task automatic t_mode_change;
    int bc;
    mode = 2'b00; load_ptr(6'd5);
    send_byte(8'h69, 1'b1, bc);
    check(bc == 2, "R11 busy cycles", bc, 2);
    compare_mem("R11 mode sampled at accept");
  endtask

  task automatic t_held;
    logic [1:0] m = 2'b10;
    mode = m; load_ptr(6'd12);
    @(negedge clk);
    byte_vld = 1'b1; byte_in = 8'h1B;
    @(negedge clk);
    check(busy, "R9 busy after accept", int'(busy), 1);
    byte_in = 8'hE4;
    while (busy) @(negedge clk);
    @(negedge clk);
    byte_vld = 1'b0;
    check(busy, "R9 second byte taken", int'(busy), 1);
    while (busy) @(negedge clk);
    model_byte(8'h1B, m);
    model_byte(8'hE4, m);
    compare_mem("R9 no data lost under hold");
    check(wr_addr == 20, "R9 pointer after held pair", int'(wr_addr), 20);
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) begin obs_mem[w] = '0; exp_mem[w] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_static();
    t_mux2();
    t_mux3();
    t_mux4();
    t_wrap();
    t_cs_low();
    t_load_range();
    t_mode_change();
    t_held();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule